// File: doc/BRIEF.md
# Debug-Transparent Memory Cycle Counter

This block counts the system-clock cycles in which the processor performs a memory access, signalled by an active-low memory-request line. A debug halt must not disturb the result: the count after a program has run with a debug interruption must equal the count after the same program has run without one. To achieve this, the block also watches the debug-acknowledge line. While that line is held, debug-induced traffic is excluded. This includes the pipeline refill on debug exit (one non-sequential access followed by two sequential ones) and any system-speed access performed while debug-acknowledge is forced high.

Debug-acknowledge rises one cycle before the last genuine access of the program and falls one cycle before the first new one. For this reason the count enable lags the acknowledge edges by one cycle. A registered copy of the acknowledge is combined with its current value, and the result is registered as the enable. A synchronous clear zeroes the count. The count saturates at all-ones instead of wrapping.

Top module: `memcyc_counter`

## Requirements
- R1: In a cycle where counting is enabled, clear is low and `mreq_n` is 0, `count` increases by one. The new value is visible in the following cycle. A cycle with `mreq_n` at 1 leaves `count` unchanged.
- R2: An access in the cycle where `dbg_ack` rises is counted. An access in the next cycle is also counted, because it is the last genuine access. From the second cycle after the rise, as long as `dbg_ack` stays at 1, no access is counted.
- R3: After `dbg_ack` has been high for at least two cycles and then falls, an access in the falling cycle is not counted. Counting resumes from the cycle after the fall.
- R4: Debug-induced traffic is never counted when it occurs while `dbg_ack` is held high. This covers system-speed accesses and the refill of three accesses. A trace with an inserted debug episode therefore yields the same count as the same trace without it.
- R5: A `dbg_ack` pulse lasting a single cycle never suppresses counting.
- R6: `clear` at 1 makes `count` zero in the next cycle and takes priority over a simultaneous access.
- R7: `count` saturates at its all-ones value. Further accesses leave it there until a clear or reset.
- R8: While `rst_n` is 0 at a clock edge, `count` becomes zero and counting is left enabled. An access in the first cycle after reset is therefore counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mreq_n | input | 1 | Memory request, 0 marks an access cycle |
| dbg_ack | input | 1 | Debug acknowledge, 1 while the core is halted for debug |
| clear | input | 1 | Synchronous clear of the count, active high |
| count | output | CNT_W (32) | Number of counted memory cycles |

## Verification
The vector table runs several patterns. Back-to-back accesses separated by an idle cycle show basic counting. A long acknowledge window containing a refill separates the two counted boundary cycles at the rise from the frozen interior and the uncounted falling cycle. A single-cycle acknowledge pulse shows that short pulses do not mask accesses, and a clear that coincides with an access confirms that clear has priority. A directed trace comparison runs the same program once plainly and once with a debug episode containing a system-speed access and a refill, and the two final counts must match. A narrow instance shows saturation, and a mid-run reset confirms that counting comes back enabled.

// File: rtl/mcc_pkg.sv
// Package: shared types for the debug-transparent memory cycle counter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mcc_pkg;

    // Default width of the cycle count.
    localparam int DEFAULT_CNT_W = 32;

    // Per-cycle action handed from the top-level decode to the counter.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_CLEAR = 2'd2
    } cnt_action_e;

endpackage

// File: rtl/mcc_ack_gate.sv
// Module: mcc_ack_gate
// Derives the count enable from the debug-acknowledge line with a one-cycle
// skew. The enable for a cycle is low only when acknowledge was high in both
// of the two preceding cycles. This lets the access just after the rising
// edge through and holds the count through the falling cycle.
// Assumes: dbg_ack is synchronous to clk.
module mcc_ack_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_ack,
    output logic ack_q,
    output logic cnt_en
);

    // Delayed copy of acknowledge, used for edge-relative timing.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= dbg_ack;
    end

    // Registered enable: drops only after two consecutive high acknowledge cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_en <= 1'b1;
        else        cnt_en <= !(dbg_ack && ack_q);
    end

endmodule

// File: rtl/mcc_sat_counter.sv
// Module: mcc_sat_counter
// A W-bit counter that performs the action selected for each cycle: hold,
// saturating increment or clear.
// Assumes: action is decoded combinationally and stable at the clock edge.
module mcc_sat_counter
    import mcc_pkg::*;
#(
    parameter int W = DEFAULT_CNT_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  cnt_action_e action,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Count register: reset, clear, saturating increment or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (action)
                ACT_CLEAR: count <= '0;
                ACT_INC:   if (count != CNT_MAX) count <= count + 1'b1;
                default:   count <= count;
            endcase
        end
    end

    // R1: an increment below the ceiling adds exactly one.
    a_r1_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_INC && count != CNT_MAX) |=> count == $past(count) + 1'b1);

    // R6: clear yields zero in the next cycle.
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_CLEAR) |=> count == '0);

    // R7: the ceiling is sticky until a clear.
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && action != ACT_CLEAR) |=> count == CNT_MAX);

    // R8: reset drives the count to zero.
    a_r8_reset_zero: assert property (@(posedge clk)
        (!rst_n) |=> count == '0);

endmodule

// File: rtl/memcyc_counter.sv
// Module: memcyc_counter (top)
// Counts memory-access cycles and excludes debug-induced traffic, using a
// skewed enable derived from debug acknowledge.
// Assumes: all inputs are synchronous to clk. dbg_ack is held high through
// every debug access that must be excluded.
module memcyc_counter
    import mcc_pkg::*;
#(
    parameter int CNT_W = DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreq_n,
    input  logic             dbg_ack,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic        ack_q;
    logic        cnt_en;
    cnt_action_e action;

    mcc_ack_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .dbg_ack (dbg_ack),
        .ack_q   (ack_q),
        .cnt_en  (cnt_en)
    );

    // Per-cycle action select: clear first, then enabled access, else hold.
    always_comb begin
        if (clear)                  action = ACT_CLEAR;
        else if (cnt_en && !mreq_n) action = ACT_INC;
        else                        action = ACT_HOLD;
    end

    mcc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .action (action),
        .count  (count)
    );

    // R2: two high acknowledge cycles in a row freeze the count one cycle later.
    a_r2_frozen_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ack && ack_q) |-> ##2 ($stable(count) || $past(clear)));

    // R3: once acknowledge was low in the previous cycle, an access counts.
    a_r3_resume_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_q && !mreq_n && !clear && count != CNT_MAX)
        |=> count == $past(count) + 1'b1);

endmodule

// File: tb/test_memcyc_counter.sv
module test_memcyc_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreq_n = 1'b1;
    logic        dbg_ack = 1'b0;
    logic        clear = 1'b0;
    logic [31:0] count;

    logic        n_mreq_n = 1'b1;
    logic        n_clear = 1'b0;
    logic [3:0]  n_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    memcyc_counter i_memcyc_counter (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .dbg_ack(dbg_ack),
        .clear(clear), .count(count)
    );

    memcyc_counter #(.CNT_W(4)) i_memcyc_counter_narrow (
        .clk(clk), .rst_n(rst_n), .mreq_n(n_mreq_n), .dbg_ack(1'b0),
        .clear(n_clear), .count(n_count)
    );

    // Vector bits: {mreq_n, dbg_ack, clear}; expected count after that cycle's edge.
    localparam int NV = 17;
    localparam logic [2:0] STIM [NV] = '{
        3'b000, 3'b100, 3'b000, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010,
        3'b010, 3'b000, 3'b000, 3'b010, 3'b000, 3'b000, 3'b001, 3'b100,
        3'b000
    };
    localparam int EXPV [NV] = '{
        1, 1, 2, 3, 4, 4, 4, 4, 4, 4, 5, 6, 7, 8, 0, 0, 1
    };
    localparam string TAGV [NV] = '{
        "R1", "R1", "R1", "R2", "R2", "R2", "R4", "R4",
        "R4", "R3", "R3", "R5", "R5", "R1", "R6", "R6",
        "R1"
    };

    // Program trace: 1 marks an idle cycle, 0 an access (12 accesses).
    localparam logic [15:0] PROG = 16'b1000_0100_1000_0100;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic a, input logic c);
        @(negedge clk);
        mreq_n = m; dbg_ack = a; clear = c;
        @(posedge clk);
        #1;
    endtask

    task automatic run_prog(input int first, input int last);
        for (int k = first; k <= last; k++) step(PROG[k], 1'b0, 1'b0);
    endtask

    longint plain_total;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset count", count, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            step(STIM[i][2], STIM[i][1], STIM[i][0]);
            check(TAGV[i], count, EXPV[i]);
        end

        // R8: reset mid-run with an access pending, then an access counts at once
        @(negedge clk);
        rst_n = 1'b0; mreq_n = 1'b0;
        @(posedge clk); #1;
        check("R8 mid-run reset", count, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R8 enabled after reset", count, 1);

        // R4: plain trace
        step(1'b1, 1'b0, 1'b1);
        check("R6 clear before trace", count, 0);
        run_prog(0, 15);
        plain_total = count;
        check("R4 plain trace total", count, 12);

        // R4: same trace with a debug episode inserted after element 6
        step(1'b1, 1'b0, 1'b1);
        run_prog(0, 4);
        step(PROG[5], 1'b1, 1'b0);           // acknowledge rises, real access
        step(PROG[6], 1'b1, 1'b0);           // last real access
        check("R2 boundary accesses counted", count, 6);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);              // system-speed access, ack forced high
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0);              // refill N
        step(1'b0, 1'b1, 1'b0);              // refill S
        step(1'b0, 1'b1, 1'b0);              // refill S
        check("R4 debug traffic excluded", count, 6);
        step(1'b0, 1'b0, 1'b0);              // falling cycle, not counted
        check("R3 falling cycle", count, 6);
        run_prog(7, 15);
        check("R4 debug trace matches plain", count, plain_total);

        // R7: saturation on the 4-bit instance
        @(negedge clk);
        mreq_n = 1'b1; n_mreq_n = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        check("R7 saturated", n_count, 15);
        @(negedge clk);
        n_clear = 1'b1;
        @(posedge clk); #1;
        check("R7 clear after saturation", n_count, 0);
        @(negedge clk);
        n_clear = 1'b0; n_mreq_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule